// File: doc/BRIEF.md
# Pattern-Sequenced Crossbar Switch

This block is an N-by-N crossbar joining processing-element ports in which no request ever arbitrates for an output. Routing comes from a small control memory that holds a program: an ordered list of switching patterns. Each pattern gives every output port either one source input or nothing. Each pattern also carries a hold time in cycles.

The block has two modes. In preset mode a host fills the control memory one route, one hold time or one program length at a time, and every output stays idle. A write that would give an output a second source is refused. A start pulse moves the block into run mode at pattern zero. The sequencer then holds each pattern for its hold time and steps to the next, wrapping to pattern zero after the last programmed one. Each data word crosses the switch through one register stage. A stop pulse returns the block to preset mode.

Top module: `pattern_xbar`

## Requirements
- R1: After reset the block is in preset mode (`running` low), `cur_pat` is 0, every `out_valid` bit is 0, both error pulses are low, the program length is 1, every route is invalid and every hold time is 0.
- R2: In run mode, output o in the cycle after pattern p is current carries the input word of the source that p assigns to o, with `out_valid[o]` high. If p leaves o unassigned, `out_data` for o is zero and `out_valid[o]` is low. Port k occupies bits `[k*DATA_W +: DATA_W]` of `in_data` and `out_data`.
- R3: One pattern may route the same input to several outputs at once.
- R4: A pattern stays current for the number of cycles in its hold time. A hold time of 0 behaves as 1. After that the sequencer moves to the next pattern.
- R5: With program length L (1 to `N_PAT`), the sequencer visits patterns 0 to L-1 in order and then wraps to 0.
- R6: A length write of 0 or above `N_PAT` is refused and pulses `cfg_reject` in the following cycle. The same holds for any write with `cfg_op` = 3. The other op codes are 0 for a route, 1 for a hold time and 2 for the length. Route and hold-time data sit in `cfg_src`/`cfg_valid` and `cfg_value`.
- R7: A valid route write to an output that already has a different valid source in that pattern is refused, leaves the pattern unchanged and pulses `cfg_reject` in the following cycle.
- R8: In run mode every configuration write is ignored and pulses `cfg_mode_err` in the following cycle.
- R9: A start pulse in preset mode enters run mode at pattern 0, with the first routed words in the cycle after. A start pulse in run mode has no effect.
- R10: A stop pulse in run mode returns to preset mode at the next edge, taking precedence over start. Whenever `running` is low, all `out_valid` bits are low.
- R11: Two kinds of route write are always accepted in preset mode: a write that clears an output (`cfg_valid` = 0), and a rewrite with the output's current source. After a clear, a new source can be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Enter run mode at pattern 0 |
| stop | input | 1 | Return to preset mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 route, 1 hold time, 2 length, 3 reserved |
| cfg_pat | input | PAT_W | Pattern index written |
| cfg_out | input | PORT_W | Output port of a route write |
| cfg_src | input | PORT_W | Source input of a route write |
| cfg_valid | input | 1 | Route write assigns (1) or clears (0) |
| cfg_value | input | HOLD_W | Hold time or program length |
| in_data | input | N_PORTS*DATA_W | Input words, one per port |
| out_data | output | N_PORTS*DATA_W | Registered output words |
| out_valid | output | N_PORTS | Per-output valid |
| running | output | 1 | High in run mode |
| cur_pat | output | PAT_W | Pattern currently applied |
| cfg_mode_err | output | 1 | Pulse: write attempted in run mode |
| cfg_reject | output | 1 | Pulse: write refused in preset mode |

## Verification
The assertions assume that `start`, `stop` and `cfg_we` are known (0 or 1) at every clock edge after reset. They also assume that `cfg_pat` and `cfg_out` index real entries. With the default power-of-two sizes, every index is a real entry. The stimulus drives only defined values, changes them on the falling edge, and keeps every index inside the configured sizes. The only out-of-range values it drives are in the program length, which is the field R6 is about.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    OP_ROUTE = 2'd0,
    OP_HOLD  = 2'd1,
    OP_LEN   = 2'd2,
    OP_RSVD  = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/xbar_ctrl_mem.sv
module xbar_ctrl_mem
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int N_PAT   = 8,
  parameter int HOLD_W  = 8,
  parameter int PORT_W  = $clog2(N_PORTS),
  parameter int PAT_W   = $clog2(N_PAT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_allow,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_op,
  input  logic [PAT_W-1:0]          cfg_pat,
  input  logic [PORT_W-1:0]         cfg_out,
  input  logic [PORT_W-1:0]         cfg_src,
  input  logic                      cfg_valid,
  input  logic [HOLD_W-1:0]         cfg_value,
  input  logic [PAT_W-1:0]          rd_pat,
  output logic [N_PORTS*PORT_W-1:0] rd_src,
  output logic [N_PORTS-1:0]        rd_vld,
  output logic [HOLD_W-1:0]         rd_hold,
  output logic [PAT_W-1:0]          last_pat,
  output logic                      cfg_mode_err,
  output logic                      cfg_reject
);
  localparam int TBL_W = N_PAT * N_PORTS * (PORT_W + 1);

  logic [PORT_W-1:0]  src_q  [N_PAT][N_PORTS];
  logic [N_PORTS-1:0] vld_q  [N_PAT];
  logic [HOLD_W-1:0]  hold_q [N_PAT];
  logic [PAT_W-1:0]   last_q;

  cfg_op_e op;
  assign op = cfg_op_e'(cfg_op);

  logic pat_ok, out_ok;
  generate
    if (N_PAT == (1 << PAT_W)) begin : g_pat_full
      assign pat_ok = 1'b1;
    end else begin : g_pat_part
      assign pat_ok = ({1'b0, cfg_pat} < (PAT_W+1)'(N_PAT));
    end
    if (N_PORTS == (1 << PORT_W)) begin : g_out_full
      assign out_ok = 1'b1;
    end else begin : g_out_part
      assign out_ok = ({1'b0, cfg_out} < (PORT_W+1)'(N_PORTS));
    end
  endgenerate

  function automatic logic len_legal(input logic [HOLD_W-1:0] v);
    return (v != '0) && (int'(v) <= N_PAT);
  endfunction

  // Named write events for the checks
  logic conflict, bad_wr, wr_blocked, wr_refused, wr_taken;
  assign conflict   = cfg_valid && vld_q[cfg_pat][cfg_out] && (src_q[cfg_pat][cfg_out] != cfg_src);
  assign bad_wr     = !pat_ok || (op == OP_RSVD) ||
                      ((op == OP_ROUTE) && (!out_ok || conflict)) ||
                      ((op == OP_LEN) && !len_legal(cfg_value));
  assign wr_blocked = cfg_we && !wr_allow;
  assign wr_refused = cfg_we && wr_allow && bad_wr;
  assign wr_taken   = cfg_we && wr_allow && !bad_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PAT; p++) begin
        vld_q[p]  <= '0;
        hold_q[p] <= '0;
        for (int o = 0; o < N_PORTS; o++) src_q[p][o] <= '0;
      end
      last_q       <= '0;
      cfg_mode_err <= 1'b0;
      cfg_reject   <= 1'b0;
    end else begin
      cfg_mode_err <= wr_blocked;
      cfg_reject   <= wr_refused;
      if (wr_taken) begin
        case (op)
          OP_ROUTE: begin
            vld_q[cfg_pat][cfg_out] <= cfg_valid;
            src_q[cfg_pat][cfg_out] <= cfg_src;
          end
          OP_HOLD: hold_q[cfg_pat] <= cfg_value;
          OP_LEN:  last_q <= PAT_W'(cfg_value - HOLD_W'(1));
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int o = 0; o < N_PORTS; o++) rd_src[o*PORT_W +: PORT_W] = src_q[rd_pat][o];
  end
  assign rd_vld   = vld_q[rd_pat];
  assign rd_hold  = hold_q[rd_pat];
  assign last_pat = last_q;

  // Flattened route table, observed by the assertions
  logic [TBL_W-1:0] tbl_flat;
  always_comb begin
    for (int p = 0; p < N_PAT; p++)
      for (int o = 0; o < N_PORTS; o++)
        tbl_flat[(p*N_PORTS + o)*(PORT_W+1) +: (PORT_W+1)] = {vld_q[p][o], src_q[p][o]};
  end

  AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |=> ($stable(tbl_flat) && $stable(last_q))); // R8
  AST_REFUSED_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |-> $stable(tbl_flat)); // R7
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_reject, cfg_mode_err})); // R6
endmodule

// File: rtl/xbar_sequencer.sv
module xbar_sequencer #(
  parameter int PAT_W  = 3,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [HOLD_W-1:0] hold,
  input  logic [PAT_W-1:0]  last_pat,
  output logic              running,
  output logic [PAT_W-1:0]  pat,
  output logic              active
);
  logic              run_q;
  logic [PAT_W-1:0]  pat_q;
  logic [HOLD_W-1:0] cnt_q;

  // Hold time of 0 counts as 1
  function automatic logic hold_done(input logic [HOLD_W-1:0] c, input logic [HOLD_W-1:0] h);
    return (h <= HOLD_W'(1)) || (c == h - HOLD_W'(1));
  endfunction

  function automatic logic [PAT_W-1:0] next_pat(input logic [PAT_W-1:0] p, input logic [PAT_W-1:0] l);
    return (p >= l) ? '0 : p + PAT_W'(1);
  endfunction

  logic start_ev, stop_ev, adv_ev;
  assign start_ev = !run_q && start;
  assign stop_ev  = run_q && stop;
  assign active   = run_q && !stop;
  assign adv_ev   = active && hold_done(cnt_q, hold);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pat_q <= '0;
      cnt_q <= '0;
    end else if (start_ev) begin
      run_q <= 1'b1;
      pat_q <= '0;
      cnt_q <= '0;
    end else if (stop_ev) begin
      run_q <= 1'b0;
    end else if (adv_ev) begin
      pat_q <= next_pat(pat_q, last_pat);
      cnt_q <= '0;
    end else if (active) begin
      cnt_q <= cnt_q + HOLD_W'(1);
    end
  end

  assign running = run_q;
  assign pat     = pat_q;

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (pat_q == '0 && cnt_q == '0)); // R9
  AST_PAT_IN_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pat_q <= last_pat)); // R5
  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && pat_q != $past(pat_q)) |->
      (pat_q == '0 || pat_q == $past(pat_q) + PAT_W'(1))); // R4
  AST_STOP_LEAVES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && stop) |=> !run_q); // R10
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16,
  parameter int PORT_W  = $clog2(N_PORTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      active,
  input  logic [N_PORTS*PORT_W-1:0] sel_src,
  input  logic [N_PORTS-1:0]        sel_vld,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  output logic [N_PORTS*DATA_W-1:0] out_data,
  output logic [N_PORTS-1:0]        out_valid
);
  genvar o;
  generate
    for (o = 0; o < N_PORTS; o++) begin : g_out
      logic [PORT_W-1:0] src;
      logic              use_it;
      logic [DATA_W-1:0] word_q;
      logic              vld_q;

      assign src    = sel_src[o*PORT_W +: PORT_W];
      assign use_it = active && sel_vld[o];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          word_q <= '0;
          vld_q  <= 1'b0;
        end else begin
          vld_q  <= use_it;
          word_q <= use_it ? in_data[src*DATA_W +: DATA_W] : '0;
        end
      end

      assign out_data[o*DATA_W +: DATA_W] = word_q;
      assign out_valid[o] = vld_q;

      AST_IDLE_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |-> (word_q == '0)); // R2
    end
  endgenerate
endmodule

// File: rtl/pattern_xbar.sv
module pattern_xbar
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16,
  parameter int N_PAT   = 8,
  parameter int HOLD_W  = 8,
  parameter int PORT_W  = $clog2(N_PORTS),
  parameter int PAT_W   = $clog2(N_PAT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      stop,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_op,
  input  logic [PAT_W-1:0]          cfg_pat,
  input  logic [PORT_W-1:0]         cfg_out,
  input  logic [PORT_W-1:0]         cfg_src,
  input  logic                      cfg_valid,
  input  logic [HOLD_W-1:0]         cfg_value,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  output logic [N_PORTS*DATA_W-1:0] out_data,
  output logic [N_PORTS-1:0]        out_valid,
  output logic                      running,
  output logic [PAT_W-1:0]          cur_pat,
  output logic                      cfg_mode_err,
  output logic                      cfg_reject
);
  logic [N_PORTS*PORT_W-1:0] rd_src;
  logic [N_PORTS-1:0]        rd_vld;
  logic [HOLD_W-1:0]         rd_hold;
  logic [PAT_W-1:0]          last_pat;
  logic                      active;

  xbar_ctrl_mem #(
    .N_PORTS(N_PORTS), .N_PAT(N_PAT), .HOLD_W(HOLD_W), .PORT_W(PORT_W), .PAT_W(PAT_W)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_allow(!running),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_pat(cfg_pat), .cfg_out(cfg_out),
    .cfg_src(cfg_src), .cfg_valid(cfg_valid), .cfg_value(cfg_value),
    .rd_pat(cur_pat), .rd_src(rd_src), .rd_vld(rd_vld), .rd_hold(rd_hold),
    .last_pat(last_pat), .cfg_mode_err(cfg_mode_err), .cfg_reject(cfg_reject)
  );

  xbar_sequencer #(.PAT_W(PAT_W), .HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .hold(rd_hold), .last_pat(last_pat),
    .running(running), .pat(cur_pat), .active(active)
  );

  xbar_datapath #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .PORT_W(PORT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .active(active),
    .sel_src(rd_src), .sel_vld(rd_vld), .in_data(in_data),
    .out_data(out_data), .out_valid(out_valid)
  );

  AST_IDLE_IN_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (out_valid == '0)); // R10
  AST_NO_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (out_valid == '0)); // R9
endmodule

// File: tb/tb_pattern_xbar.sv
module tb_pattern_xbar;
  localparam int N   = 8;
  localparam int DW  = 16;
  localparam int NP  = 8;
  localparam int HW  = 8;
  localparam int PW  = $clog2(N);
  localparam int EW  = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [1:0]      cfg_op = '0;
  logic [EW-1:0]   cfg_pat = '0;
  logic [PW-1:0]   cfg_out = '0, cfg_src = '0;
  logic [HW-1:0]   cfg_value = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N*DW-1:0] out_data;
  logic [N-1:0]    out_valid;
  logic            running, cfg_mode_err, cfg_reject;
  logic [EW-1:0]   cur_pat;

  always #5 clk = ~clk;

  pattern_xbar #(.N_PORTS(N), .DATA_W(DW), .N_PAT(NP), .HOLD_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cfg_we(cfg_we),
    .cfg_op(cfg_op), .cfg_pat(cfg_pat), .cfg_out(cfg_out), .cfg_src(cfg_src),
    .cfg_valid(cfg_valid), .cfg_value(cfg_value), .in_data(in_data),
    .out_data(out_data), .out_valid(out_valid), .running(running),
    .cur_pat(cur_pat), .cfg_mode_err(cfg_mode_err), .cfg_reject(cfg_reject)
  );

  int checks = 0, errors = 0, cyc_no = 0;
  bit done = 1'b0;

  // Reference program model
  int m_src [NP][N];
  bit m_vld [NP][N];
  int m_hold [NP];
  int m_len = 1;
  bit m_run = 1'b0;
  int m_pat = 0, m_cnt = 0;

  // Scoreboard queues
  logic [N*DW-1:0] q_data [$];
  logic [N-1:0]    q_valid [$];
  logic [EW+2:0]   q_ctl [$];
  string           q_tag [$];

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_hold[p] = 0;
      for (int o = 0; o < N; o++) begin m_src[p][o] = 0; m_vld[p][o] = 1'b0; end
    end
  end

  // Driver: one clock cycle of stimulus plus its expected result
  task automatic cyc(input bit st, input bit sp, input bit we, input int op, input int pat,
                     input int o, input int s, input bit v, input int val, input string tag);
    logic [N*DW-1:0] ed;
    logic [N-1:0]    ev;
    bit bad, act, merr, rej;
    @(negedge clk);
    start = st; stop = sp; cfg_we = we; cfg_op = 2'(op); cfg_pat = EW'(pat);
    cfg_out = PW'(o); cfg_src = PW'(s); cfg_valid = v; cfg_value = HW'(val);
    for (int k = 0; k < N; k++) in_data[k*DW +: DW] = DW'(((cyc_no & 255) << 8) | (k * 17 + 3));
    cyc_no++;
    act = m_run && !sp;
    ed = '0; ev = '0;
    for (int k = 0; k < N; k++)
      if (act && m_vld[m_pat][k]) begin
        ev[k] = 1'b1;
        ed[k*DW +: DW] = in_data[m_src[m_pat][k]*DW +: DW];
      end
    bad = (op == 3) || (op == 2 && (val == 0 || val > NP)) ||
          (op == 0 && v && m_vld[pat][o] && m_src[pat][o] != s);
    merr = we && m_run;
    rej  = we && !m_run && bad;
    if (we && !m_run && !bad) begin
      if (op == 0) begin m_vld[pat][o] = v; m_src[pat][o] = s; end
      else if (op == 1) m_hold[pat] = val;
      else if (op == 2) m_len = val;
    end
    if (!m_run && st) begin m_run = 1'b1; m_pat = 0; m_cnt = 0; end
    else if (m_run && sp) m_run = 1'b0;
    else if (act) begin
      if (m_cnt + 1 >= ((m_hold[m_pat] == 0) ? 1 : m_hold[m_pat])) begin
        m_cnt = 0;
        m_pat = (m_pat >= m_len - 1) ? 0 : m_pat + 1;
      end else m_cnt++;
    end
    q_data.push_back(ed);
    q_valid.push_back(ev);
    q_ctl.push_back({m_run, EW'(m_pat), merr, rej});
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic route(input int p, input int o, input int s, input bit v, input string tag);
    cyc(0, 0, 1, 0, p, o, s, v, 0, tag);
  endtask

  // Monitor: compares results after each active edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q_tag.size() > 0) begin
        logic [N*DW-1:0] ed;
        logic [N-1:0] ev;
        logic [EW+2:0] ec;
        string tg;
        ed = q_data.pop_front(); ev = q_valid.pop_front();
        ec = q_ctl.pop_front();  tg = q_tag.pop_front();
        checks++;
        if (out_data !== ed || out_valid !== ev ||
            {running, cur_pat, cfg_mode_err, cfg_reject} !== ec) begin
          errors++;
          $display("FAIL %s: got data=%h valid=%b ctl=%b, expected data=%h valid=%b ctl=%b",
                   tg, out_data, out_valid, {running, cur_pat, cfg_mode_err, cfg_reject},
                   ed, ev, ec);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (running !== 1'b0 || out_valid !== '0 || cur_pat !== '0 || cfg_mode_err !== 1'b0 ||
        cfg_reject !== 1'b0) begin
      errors++;
      $display("FAIL R1: got run=%b valid=%b pat=%0d errs=%b%b, expected all zero",
               running, out_valid, cur_pat, cfg_mode_err, cfg_reject);
    end
    idle(2, "R1");
    // Pattern 0: one input to two outputs, plus a third route
    route(0, 0, 3, 1, "R3");
    route(0, 1, 3, 1, "R3");
    route(0, 2, 5, 1, "R2");
    cyc(0, 0, 1, 1, 0, 0, 0, 0, 3, "R4");
    route(1, 0, 1, 1, "R2");
    route(1, 7, 0, 1, "R2");
    cyc(0, 0, 1, 1, 1, 0, 0, 0, 0, "R4");
    route(2, 4, 4, 1, "R2");
    cyc(0, 0, 1, 1, 2, 0, 0, 0, 2, "R4");
    // Bad lengths and reserved op
    cyc(0, 0, 1, 2, 0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 1, 2, 0, 0, 0, 0, 9, "R6");
    cyc(0, 0, 1, 3, 0, 0, 0, 0, 1, "R6");
    cyc(0, 0, 1, 2, 0, 0, 0, 0, 3, "R5");
    // Second source for an occupied output
    route(0, 2, 6, 1, "R7");
    route(0, 0, 3, 1, "R11");
    route(0, 2, 0, 0, "R11");
    route(0, 2, 6, 1, "R11");
    // Run
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    idle(3, "R4");
    idle(10, "R5");
    route(0, 5, 2, 1, "R8");
    cyc(0, 0, 1, 2, 0, 0, 0, 0, 1, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    idle(8, "R8");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R10");
    idle(3, "R10");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R10");
    // Shorter program, then stop wins over start
    cyc(0, 0, 1, 2, 0, 0, 0, 0, 2, "R5");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    idle(9, "R5");
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, "R10");
    idle(3, "R10");
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0; stop = 1'b0;
    repeat (2) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule